// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether a frame is kept, using only the frame's 48-bit destination address. The MAC presents the six address bytes one per valid cycle, first byte on the wire first, after pulsing a frame-start strobe. While the bytes arrive, the filter runs a CRC-32 over them and compares each byte against a programmed station address. One cycle after the sixth byte it raises a verdict. The verdict stays fixed until the next frame start.

Addresses whose group bit is set are looked up in a 256-bit hash table. That table is stored as eight 32-bit words. Software can load each word whole through a simple register write port. It can also set or clear the single entry that belongs to a given 48-bit address through a command port, and the block computes that address's hash itself. The broadcast address always passes, and a promiscuous control bit makes every frame pass.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, verdict_valid is 0, all eight hash words are zero, the station address is zero and promiscuous mode is off, so a group-address frame is rejected.
- R2: A frame whose first byte has bit 0 clear is accepted only when all six bytes equal the station address. Register offset 0 holds bytes 5,4,3,2 from MSB to LSB, and offset 1 holds bytes 1,0 in bits 31:16, with bits 15:0 ignored. Writing 0xCDAB7856 and 0x34120000 therefore selects 12:34:56:78:AB:CD.
- R3: The hash runs over the six bytes in order, each byte LSB first. It starts from all ones, uses generator 0x04C11DB7 with a left shift, and applies no final inversion. Bits 31:24 of the result form the index. Index bits 7:5 pick hash word n, which is written at register offset 8+n. The entry sits at bit 31 minus index bits 4:0.
- R4: The broadcast address FF:FF:FF:FF:FF:FF is accepted whatever the table holds.
- R5: Bit 3 of the control register at offset 2 enables promiscuous mode, in which every frame is accepted. The other bits of that register have no effect.
- R6: A command with cmd_set=1 ORs in the entry of cmd_addr, where byte 0 is bits 47:40. A command with cmd_set=0 clears that entry. All other table bits are left unchanged.
- R7: verdict_valid rises in the cycle after the edge that takes the sixth byte. It then holds together with accept until frame_start, which clears it at the next edge.
- R8: Bytes after the sixth are ignored. Register and command changes made after the verdict do not change it.
- R9: When a register write and a command target the same hash word in one cycle, the register write wins.
- R10: For a frame with the group bit set, the station compare plays no part, even when the address equals the station address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a new frame and clears the verdict |
| byte_valid | input | 1 | byte_data carries an address byte |
| byte_data | input | 8 | Destination address byte |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register offset: 0,1 station, 2 control, 8-15 hash words |
| reg_wr_data | input | 32 | Register write data |
| cmd_valid | input | 1 | Entry command strobe |
| cmd_set | input | 1 | 1 sets the entry, 0 clears it |
| cmd_addr | input | 48 | Address whose hash entry is changed, byte 0 in bits 47:40 |
| verdict_valid | output | 1 | Verdict available |
| accept | output | 1 | Frame accepted when verdict_valid is 1 |

## Verification
The verdict is due exactly one edge after the sixth byte is taken. The bench therefore checks that verdict_valid is still low on the falling edge during which the sixth byte is driven, and it samples verdict_valid and accept on the next falling edge. A register write or a command takes effect at the edge it is driven on, so the frame that follows it sees the new table. After frame_start, the cleared verdict is checked on the following falling edge. Holding and ignored-input cases are checked by sampling the verdict again several cycles after the disturbing stimulus.

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int          HASH_WORDS  = 8,
  parameter int          PROMISC_BIT = 3,
  parameter logic [31:0] CRC_POLY    = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic        reg_wr_en,
  input  logic [3:0]  reg_wr_addr,
  input  logic [31:0] reg_wr_data,
  input  logic        cmd_valid,
  input  logic        cmd_set,
  input  logic [47:0] cmd_addr,
  output logic        verdict_valid,
  output logic        accept
);
  localparam int IDX_W  = $clog2(HASH_WORDS * 32);
  localparam int WORD_W = IDX_W - 5;
  localparam logic [2:0] N_BYTES = 3'd6;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = d[i] ^ r[31];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] addr_index(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) c = crc_step(c, a[47-8*k -: 8]);
    return c[31 -: IDX_W];
  endfunction

  logic [31:0] sta_w1;
  logic [15:0] sta_w2;
  logic        promisc;
  logic [31:0] hash_q [HASH_WORDS];

  logic [2:0]  cnt;
  logic [31:0] crc_q;
  logic        uc_ok, bc_ok, grp;

  logic [7:0]  sta_byte;
  always_comb begin
    case (cnt)
      3'd0:    sta_byte = sta_w2[7:0];
      3'd1:    sta_byte = sta_w2[15:8];
      3'd2:    sta_byte = sta_w1[7:0];
      3'd3:    sta_byte = sta_w1[15:8];
      3'd4:    sta_byte = sta_w1[23:16];
      default: sta_byte = sta_w1[31:24];
    endcase
  end

  wire              take   = byte_valid && !frame_start && (cnt < N_BYTES);
  wire              last   = take && (cnt == N_BYTES - 3'd1);
  wire [31:0]       crc_n  = crc_step(crc_q, byte_data);
  wire              uc_n   = uc_ok && (byte_data == sta_byte);
  wire              bc_n   = bc_ok && (byte_data == 8'hFF);
  wire              grp_n  = (cnt == 3'd0) ? byte_data[0] : grp;
  wire [IDX_W-1:0]  rx_idx = crc_n[31 -: IDX_W];
  wire [31:0]       rx_wd  = hash_q[rx_idx[IDX_W-1:5]];
  wire              hit    = rx_wd[~rx_idx[4:0]];
  wire              verdict_n = promisc | bc_n | (grp_n ? hit : uc_n);

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      cnt           <= '0;
      crc_q         <= 32'hFFFF_FFFF;
      uc_ok         <= 1'b1;
      bc_ok         <= 1'b1;
      grp           <= 1'b0;
      verdict_valid <= 1'b0;
      accept        <= 1'b0;
    end else if (take) begin
      cnt   <= cnt + 3'd1;
      crc_q <= crc_n;
      uc_ok <= uc_n;
      bc_ok <= bc_n;
      grp   <= grp_n;
      if (last) begin
        verdict_valid <= 1'b1;
        accept        <= verdict_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_w1  <= '0;
      sta_w2  <= '0;
      promisc <= 1'b0;
    end else if (reg_wr_en) begin
      case (reg_wr_addr)
        4'd0:    sta_w1  <= reg_wr_data;
        4'd1:    sta_w2  <= reg_wr_data[31:16];
        4'd2:    promisc <= reg_wr_data[PROMISC_BIT];
        default: ;
      endcase
    end
  end

  wire [IDX_W-1:0] cmd_idx  = addr_index(cmd_addr);
  wire [31:0]      cmd_mask = 32'h1 << (5'd31 - cmd_idx[4:0]);

  for (genvar r = 0; r < HASH_WORDS; r++) begin : g_hash
    always_ff @(posedge clk) begin
      if (!rst_n)
        hash_q[r] <= '0;
      else if (reg_wr_en && reg_wr_addr == 4'(8 + r))
        hash_q[r] <= reg_wr_data;
      else if (cmd_valid && cmd_idx[IDX_W-1:5] == WORD_W'(r))
        hash_q[r] <= cmd_set ? (hash_q[r] | cmd_mask) : (hash_q[r] & ~cmd_mask);
    end
  end

  assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !verdict_valid);
  assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && !frame_start |=> verdict_valid && $stable(accept));
  assert_rise_after_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(verdict_valid) |-> $past(byte_valid));
  assert_six_bytes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> cnt == N_BYTES);
  assert_promisc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last && promisc |=> accept);
endmodule

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0, byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic        cmd_valid = 1'b0, cmd_set = 1'b0;
  logic [47:0] cmd_addr = '0;
  logic        verdict_valid, accept;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dest_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
    .cmd_addr(cmd_addr), .verdict_valid(verdict_valid), .accept(accept));

  logic [7:0]  m_sta [6];
  logic [31:0] m_hash [8];
  bit          m_prom;

  function automatic int hidx(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int i = 0; i < 8; i++) begin
        bit fb = b[i] ^ c[31];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return int'(c[31:24]);
  endfunction

  function automatic bit expect_acc(input logic [47:0] a);
    int ix;
    if (m_prom) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (a[40]) begin
      ix = hidx(a);
      return m_hash[ix / 32][31 - (ix % 32)];
    end
    for (int k = 0; k < 6; k++) if (a[47-8*k -: 8] != m_sta[k]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ad, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = ad; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    case (ad)
      4'd0: begin m_sta[5] = d[31:24]; m_sta[4] = d[23:16]; m_sta[3] = d[15:8]; m_sta[2] = d[7:0]; end
      4'd1: begin m_sta[1] = d[31:24]; m_sta[0] = d[23:16]; end
      4'd2: m_prom = d[3];
      default: if (ad >= 4'd8) m_hash[ad - 4'd8] = d;
    endcase
  endtask

  task automatic cmd(input bit set, input logic [47:0] a);
    int ix = hidx(a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_set = set; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (set) m_hash[ix / 32][31 - (ix % 32)] = 1'b1;
    else     m_hash[ix / 32][31 - (ix % 32)] = 1'b0;
  endtask

  task automatic frame(input logic [47:0] a, input string req);
    bit e = expect_acc(a);
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check({req, " R7 cleared by frame_start"}, 32'(verdict_valid), 0);
    for (int k = 0; k < 6; k++) begin
      byte_valid = 1'b1; byte_data = a[47-8*k -: 8];
      if (k == 5) check({req, " R7 not early"}, 32'(verdict_valid), 0);
      @(negedge clk);
    end
    byte_valid = 1'b0;
    check({req, " R7 valid"}, 32'(verdict_valid), 1);
    check({req, " accept"}, 32'(accept), 32'(e));
  endtask

  logic [47:0] g, h, a;

  initial begin
    for (int k = 0; k < 6; k++) m_sta[k] = '0;
    for (int r = 0; r < 8; r++) m_hash[r] = '0;
    m_prom = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", 32'(verdict_valid), 0);
    frame(48'h01005E000001, "R1 group after reset");
    frame(48'h020000000001, "R1 unicast after reset");

    wr(4'd0, 32'hCDAB7856);
    wr(4'd1, 32'h3412FFFF);
    frame(48'h12345678ABCD, "R2 station match");
    check("R2 example accepted", 32'(accept), 1);
    frame(48'h12345678ABCC, "R2 last byte differs");
    frame(48'h14345678ABCD, "R2 first byte differs");

    wr(4'd1, 32'h34130000);
    frame(48'h13345678ABCD, "R10 group equals station");
    check("R10 rejected", 32'(accept), 0);
    wr(4'd1, 32'h34120000);

    frame(48'hFFFFFFFFFFFF, "R4 broadcast");
    check("R4 broadcast accepted", 32'(accept), 1);

    g = 48'h01005E0000AA;
    h = 48'h01005E000010;
    while (hidx(h) == hidx(g)) h = h + 48'd1;
    cmd(1'b1, g);
    frame(g, "R6 set entry");
    check("R6 set accepted", 32'(accept), 1);
    frame(h, "R6 other entry");
    cmd(1'b1, h);
    cmd(1'b0, g);
    frame(g, "R6 cleared entry");
    check("R6 cleared rejected", 32'(accept), 0);
    frame(h, "R6 untouched entry");
    check("R6 untouched accepted", 32'(accept), 1);
    cmd(1'b0, h);

    wr(4'(8 + hidx(g) / 32), 32'h1 << (31 - hidx(g) % 32));
    frame(g, "R3 single bit word");
    check("R3 word bit accepted", 32'(accept), 1);
    wr(4'(8 + hidx(g) / 32), ~(32'h1 << (31 - hidx(g) % 32)));
    frame(g, "R3 all but entry");
    check("R3 rejected", 32'(accept), 0);
    for (int r = 0; r < 8; r++) wr(4'(8 + r), 32'h0);

    wr(4'd2, 32'h0000_0008);
    frame(48'h0A0B0C0D0E0F, "R5 promisc");
    check("R5 promisc accepted", 32'(accept), 1);
    wr(4'd2, 32'hFFFF_FFF7);
    frame(48'h0A0B0C0D0E0F, "R5 other ctrl bits");
    check("R5 rejected", 32'(accept), 0);

    repeat (3) begin
      @(negedge clk); byte_valid = 1'b1; byte_data = 8'h12;
    end
    @(negedge clk); byte_valid = 1'b0;
    wr(4'd2, 32'h8);
    cmd(1'b1, 48'h0A0B0C0D0E0F);
    wr(4'd0, 32'h0F0E0D0C);
    repeat (4) @(negedge clk);
    check("R8 verdict held valid", 32'(verdict_valid), 1);
    check("R8 verdict held accept", 32'(accept), 0);
    wr(4'd2, 32'h0);
    wr(4'd0, 32'hCDAB7856);
    for (int r = 0; r < 8; r++) wr(4'(8 + r), 32'h0);

    cmd(1'b1, g);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = 4'(8 + hidx(g) / 32); reg_wr_data = 32'h0;
    cmd_valid = 1'b1; cmd_set = 1'b1; cmd_addr = g;
    @(negedge clk);
    reg_wr_en = 1'b0; cmd_valid = 1'b0;
    m_hash[hidx(g) / 32] = 32'h0;
    frame(g, "R9 write beats command");
    check("R9 rejected", 32'(accept), 0);

    for (int n = 0; n < 80; n++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0) wr(4'd2, $urandom & 32'hF);
      else if (sel == 1) wr(4'(8 + $urandom_range(0, 7)), $urandom);
      else if (sel == 2) cmd($urandom_range(0, 1), {8'h01, $urandom, 8'(n)});
      case ($urandom_range(0, 4))
        0: a = {m_sta[0], m_sta[1], m_sta[2], m_sta[3], m_sta[4], m_sta[5]};
        1: a = 48'hFFFFFFFFFFFF;
        2: a = {$urandom_range(0, 127) * 2 + 1, $urandom, 8'($urandom)} ;
        default: a = {8'(($urandom_range(0, 127)) * 2), $urandom, 8'($urandom)};
      endcase
      frame(a, "R2 R3 R4 R5 random");
    end

    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    check("R7 frame_start clears", 32'(verdict_valid), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule